// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block runs single accesses on an external bus where address and data use the same pins. A request carries an address, write data, a direction and byte enables. Once the sequencer accepts it, the access runs in two phases. The address phase drives the address onto the shared pins and pulses an address-latch strobe, so an external device can capture the address. The data phase then either drives write data or releases the pins so the device can return read data. A chip select frames the whole access, and read and write strobes mark the data transfer.

The address phase lasts two or three cycles, set by one configuration bit. The data phase lasts two cycles, or three cycles plus zero to seven programmed wait cycles. A further configuration bit moves the assertion edge of the read/write strobe. The configuration in force when a request is accepted holds for the whole of that access. One cycle after the last data cycle, a one-cycle done pulse presents the read data sampled from the bus.

Top module: `muxbus_seq`

## Requirements
- R1: While reset (rstN low) is held, and while idle afterwards, chipSel, aleStrb, rdStrb, wrStrb, busOe and done are all 0, and byteEn is 0.
- R2: An accepted access starts with an address phase of 2 cycles when cfgAddr3=0 and 3 cycles when cfgAddr3=1. In every address cycle chipSel=1 and busOe=1, busOut carries the request address, byteEn=0, and neither rdStrb nor wrStrb is active.
- R3: aleStrb is 1 in every address cycle except the last one, and 0 in all other cycles.
- R4: The data phase lasts 2 cycles when cfgData3=0, and cfgWaits then has no effect. When cfgData3=1 it lasts 3+cfgWaits cycles (cfgWaits 0 to 7). byteEn carries the request byte enables in every data cycle.
- R5: chipSel is 1 for exactly the address cycles plus the data cycles. done is 1 for exactly one cycle, in the first cycle after the last data cycle, when chipSel is already 0.
- R6: For a write (reqWrite=1), every data cycle has busOe=1 with busOut equal to the request write data.
- R7: For a read, busOe is 0 in every data cycle. The value on busIn during the last data cycle appears on rdData while done is 1.
- R8: With cfgStrbEarly=1 the active strobe (rdStrb for reads, wrStrb for writes) is 1 in every data cycle. With cfgStrbEarly=0 it is 0 in the first data cycle and 1 in the rest. The other strobe stays 0.
- R9: reqValid is sampled only when the sequencer is idle. A request, or a change of any cfg input, made while an access is in progress has no effect on that access and starts no further access.
- R10: A request presented in the cycle in which done is 1 is accepted, and its address phase begins in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request access (sampled only when idle) |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqWdata | input | DATA_W | Write data |
| reqByteEn | input | DATA_W/8 | Byte enables of the access |
| cfgAddr3 | input | 1 | 1 = three-cycle address phase, 0 = two |
| cfgData3 | input | 1 | 1 = three-cycle data phase plus waits, 0 = two |
| cfgWaits | input | WAIT_W | Programmed wait cycles for a three-cycle data phase |
| cfgStrbEarly | input | 1 | 1 = strobe from first data cycle, 0 = from second |
| busIn | input | BUS_W | Value sensed on the shared pins |
| busOut | output | BUS_W | Value driven on the shared pins |
| busOe | output | 1 | Output enable of the shared pins |
| aleStrb | output | 1 | Address-latch strobe |
| chipSel | output | 1 | Chip select, active high |
| rdStrb | output | 1 | Read strobe, active high |
| wrStrb | output | 1 | Write strobe, active high |
| byteEn | output | DATA_W/8 | Byte enables during the data phase |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Read data, valid while done is 1 |

## Verification
Two cases are the hardest to reach from the ports. The first is a request, or a configuration change, that arrives while an access is already running. The stimulus holds reqValid high with a different address and flips every configuration input for several mid-access cycles, then drops them before the done cycle. The monitor then confirms that the running access keeps its original lengths and address, and that no second chip-select period appears. The second case is read sampling in the last data cycle. To show it, the responder drives busIn with a value that changes on every data cycle, so a capture one cycle early or late returns a detectably wrong word.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } seqState_t;

  // strobes from the sequencer control to the datapath
  typedef struct packed {
    logic load;      // latch request fields
    logic drvAddr;   // address phase: address on the pins
    logic drvData;   // data phase
    logic capture;   // sample read data this cycle
    logic done;      // completion pulse
  } dpCtl_t;

endpackage

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
  import muxbus_pkg::*;
#(
  parameter int WAIT_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic              cfgAddr3,
  input  logic              cfgData3,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgStrbEarly,
  output dpCtl_t            ctl,
  output logic              chipSel,
  output logic              aleStrb,
  output logic              rdStrb,
  output logic              wrStrb
);

  seqState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] addrLast;
  logic [CNT_W-1:0] dataLast;
  logic             wrLat;
  logic             earlyLat;
  logic             doneQ;
  logic             lastData;
  logic             lastAddr;
  logic             strobeOn;

  assign lastAddr = (state == ST_ADDR) && (cnt == addrLast);
  assign lastData = (state == ST_DATA) && (cnt == dataLast);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      addrLast <= '0;
      dataLast <= '0;
      wrLat    <= 1'b0;
      earlyLat <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      doneQ <= lastData;
      unique case (state)
        ST_IDLE: begin
          if (reqValid) begin
            state    <= ST_ADDR;
            cnt      <= '0;
            addrLast <= cfgAddr3 ? CNT_W'(2) : CNT_W'(1);
            dataLast <= cfgData3 ? (CNT_W'(2) + CNT_W'(cfgWaits)) : CNT_W'(1);
            wrLat    <= reqWrite;
            earlyLat <= cfgStrbEarly;
          end
        end
        ST_ADDR: begin
          if (lastAddr) begin
            state <= ST_DATA;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_DATA: begin
          if (lastData) begin
            state <= ST_IDLE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign strobeOn = (state == ST_DATA) && (earlyLat || (cnt != '0));

  always_comb begin
    ctl         = '0;
    ctl.load    = (state == ST_IDLE) && reqValid;
    ctl.drvAddr = (state == ST_ADDR);
    ctl.drvData = (state == ST_DATA);
    ctl.capture = lastData && !wrLat;
    ctl.done    = doneQ;
  end

  assign chipSel = (state != ST_IDLE);
  assign aleStrb = (state == ST_ADDR) && !lastAddr;
  assign rdStrb  = strobeOn && !wrLat;
  assign wrStrb  = strobeOn && wrLat;

endmodule

// File: rtl/muxbus_dpath.sv
module muxbus_dpath
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int BUS_W  = 16,
  parameter int BE_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic [BE_W-1:0]   byteEn,
  output logic [DATA_W-1:0] rdData,
  output logic              done
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [BE_W-1:0]   beQ;
  logic              wrQ;
  logic [DATA_W-1:0] rdQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
      beQ    <= '0;
      wrQ    <= 1'b0;
      rdQ    <= '0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
        beQ    <= reqByteEn;
        wrQ    <= reqWrite;
      end
      if (ctl.capture) rdQ <= busIn[DATA_W-1:0];
    end
  end

  always_comb begin
    if (ctl.drvAddr)              busOut = BUS_W'(addrQ);
    else if (ctl.drvData && wrQ)  busOut = BUS_W'(wdataQ);
    else                          busOut = '0;
  end

  assign busOe  = ctl.drvAddr || (ctl.drvData && wrQ);
  assign byteEn = ctl.drvData ? beQ : '0;
  assign rdData = rdQ;
  assign done   = ctl.done;

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
  import muxbus_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16,
  parameter int WAIT_W = 3,
  localparam int BUS_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2((2 ** WAIT_W) + 3)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [BE_W-1:0]   reqByteEn,
  input  logic              cfgAddr3,
  input  logic              cfgData3,
  input  logic [WAIT_W-1:0] cfgWaits,
  input  logic              cfgStrbEarly,
  input  logic [BUS_W-1:0]  busIn,
  output logic [BUS_W-1:0]  busOut,
  output logic              busOe,
  output logic              aleStrb,
  output logic              chipSel,
  output logic              rdStrb,
  output logic              wrStrb,
  output logic [BE_W-1:0]   byteEn,
  output logic              done,
  output logic [DATA_W-1:0] rdData
);

  dpCtl_t ctl;

  muxbus_ctrl #(
    .WAIT_W(WAIT_W),
    .CNT_W (CNT_W)
  ) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .cfgAddr3    (cfgAddr3),
    .cfgData3    (cfgData3),
    .cfgWaits    (cfgWaits),
    .cfgStrbEarly(cfgStrbEarly),
    .ctl         (ctl),
    .chipSel     (chipSel),
    .aleStrb     (aleStrb),
    .rdStrb      (rdStrb),
    .wrStrb      (wrStrb)
  );

  muxbus_dpath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .BUS_W (BUS_W),
    .BE_W  (BE_W)
  ) uDpath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .reqByteEn(reqByteEn),
    .reqWrite (reqWrite),
    .busIn    (busIn),
    .busOut   (busOut),
    .busOe    (busOe),
    .byteEn   (byteEn),
    .rdData   (rdData),
    .done     (done)
  );

endmodule

// File: rtl/muxbus_seq_chk.sv
module muxbus_seq_chk #(
  parameter int BUS_W = 16,
  parameter int BE_W  = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic [BUS_W-1:0] busOut,
  input logic             busOe,
  input logic             aleStrb,
  input logic             chipSel,
  input logic             rdStrb,
  input logic             wrStrb,
  input logic [BE_W-1:0]  byteEn,
  input logic             done
);

  // R3
  ale_in_addr_chk: assert property (@(posedge clk) disable iff (!rstN)
    aleStrb |-> (chipSel && busOe && !rdStrb && !wrStrb && (byteEn == '0)));

  // R3
  ale_fall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(aleStrb) |-> (chipSel && busOe && (byteEn == '0)));

  // R7
  read_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdStrb |-> !busOe);

  // R6
  write_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStrb |-> busOe);

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdStrb && wrStrb));

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5
  done_after_cs_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(chipSel) |-> done);

  // R9
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chipSel && $past(chipSel) && (byteEn == '0)) |-> $stable(busOut));

endmodule

bind muxbus_seq muxbus_seq_chk #(
  .BUS_W(BUS_W),
  .BE_W (BE_W)
) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .busOut (busOut),
  .busOe  (busOe),
  .aleStrb(aleStrb),
  .chipSel(chipSel),
  .rdStrb (rdStrb),
  .wrStrb (wrStrb),
  .byteEn (byteEn),
  .done   (done)
);

// File: tb/muxbus_seq_test.sv
module muxbus_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic [15:0] reqWdata = '0;
  logic [1:0]  reqByteEn = '0;
  logic        cfgAddr3 = 1'b0;
  logic        cfgData3 = 1'b0;
  logic [2:0]  cfgWaits = '0;
  logic        cfgStrbEarly = 1'b0;
  logic [15:0] busIn = '0;
  logic [15:0] busOut;
  logic        busOe, aleStrb, chipSel, rdStrb, wrStrb, done;
  logic [1:0]  byteEn;
  logic [15:0] rdData;

  always #10 clk = ~clk;

  muxbus_seq uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqByteEn(reqByteEn),
    .cfgAddr3(cfgAddr3), .cfgData3(cfgData3), .cfgWaits(cfgWaits),
    .cfgStrbEarly(cfgStrbEarly), .busIn(busIn), .busOut(busOut),
    .busOe(busOe), .aleStrb(aleStrb), .chipSel(chipSel), .rdStrb(rdStrb),
    .wrStrb(wrStrb), .byteEn(byteEn), .done(done), .rdData(rdData)
  );

  typedef struct {
    logic [15:0] addr;
    logic [15:0] wdata;
    logic [1:0]  be;
    logic        wr;
    int          aLen;
    int          dLen;
    logic        early;
    logic [15:0] rdBase;
  } item_t;

  item_t expQ[$];
  item_t cur;
  int    checks = 0;
  int    errors = 0;
  int    issued = 0;
  int    accesses = 0;
  bit    active = 0;
  bit    finished = 0;
  int    aIdx, dIdx;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: called at a negedge, pushes the expected access
  task automatic issue(input logic [15:0] a, input logic [15:0] wd, input logic [1:0] be,
                       input logic wr, input logic a3, input logic d3, input logic [2:0] w,
                       input logic early, input logic [15:0] rb);
    item_t it;
    reqAddr = a; reqWdata = wd; reqByteEn = be; reqWrite = wr;
    cfgAddr3 = a3; cfgData3 = d3; cfgWaits = w; cfgStrbEarly = early;
    reqValid = 1'b1;
    it.addr = a; it.wdata = wd; it.be = be; it.wr = wr;
    it.aLen = a3 ? 3 : 2;
    it.dLen = d3 ? 3 + int'(w) : 2;
    it.early = early; it.rdBase = rb;
    expQ.push_back(it);
    issued++;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    do @(negedge clk); while (!done);
  endtask

  // monitor / responder
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        if (chipSel && !active) begin
          if (expQ.size() == 0) begin
            chk(1'b0, "R9 stray access", 1, 0);
            cur = '{default: '0};
          end else begin
            cur = expQ.pop_front();
          end
          active = 1; aIdx = 0; dIdx = 0;
        end
        if (chipSel) begin
          chk(done == 1'b0, "R5 done during access", done, 0);
          if (byteEn == 2'b00) begin
            chk(busOe && busOut == cur.addr, "R2 address on bus", busOut, cur.addr);
            chk(!rdStrb && !wrStrb, "R2 no strobe in address phase", {rdStrb, wrStrb}, 0);
            chk(aleStrb == (aIdx < cur.aLen - 1), "R3 ale timing", aleStrb, aIdx < cur.aLen - 1);
            aIdx++;
          end else begin
            if (dIdx == 0) chk(aIdx == cur.aLen, "R2 address phase length", aIdx, cur.aLen);
            chk(byteEn == cur.be, "R4 byte enables", byteEn, cur.be);
            chk(!aleStrb, "R3 ale low in data phase", aleStrb, 0);
            chk(busOe == cur.wr, "R6/R7 output enable", busOe, cur.wr);
            if (cur.wr) chk(busOut == cur.wdata, "R6 write data", busOut, cur.wdata);
            chk(rdStrb == (!cur.wr && (cur.early || dIdx != 0)), "R8 read strobe", rdStrb,
                !cur.wr && (cur.early || dIdx != 0));
            chk(wrStrb == (cur.wr && (cur.early || dIdx != 0)), "R8 write strobe", wrStrb,
                cur.wr && (cur.early || dIdx != 0));
            busIn = cur.rdBase + 16'(dIdx);
            dIdx++;
          end
        end else if (active) begin
          chk(done == 1'b1, "R5 done after access", done, 1);
          chk(dIdx == cur.dLen, "R4 data phase length", dIdx, cur.dLen);
          if (!cur.wr)
            chk(rdData == cur.rdBase + 16'(cur.dLen - 1), "R7 read sample", rdData,
                cur.rdBase + 16'(cur.dLen - 1));
          active = 0;
          accesses++;
          busIn = 16'hDEAD;
        end else begin
          chk(done == 1'b0, "R1 done low when idle", done, 0);
          chk(!aleStrb && !rdStrb && !wrStrb && !busOe && byteEn == 0, "R1 idle outputs",
              {aleStrb, rdStrb, wrStrb, busOe, byteEn}, 0);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({chipSel, aleStrb, rdStrb, wrStrb, busOe, done} == 6'b0 && byteEn == 0,
        "R1 reset outputs", {chipSel, aleStrb, rdStrb, wrStrb, busOe, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(!chipSel && !done, "R1 idle after reset", {chipSel, done}, 0);

    issue(16'h1234, 16'hA5A5, 2'b11, 1, 0, 0, 3'd0, 0, 16'h0);      // shortest write
    waitDone();
    issue(16'h2001, 16'h0,    2'b01, 0, 1, 0, 3'd0, 0, 16'h5100);   // R10 back-to-back read
    waitDone();
    issue(16'h3FFE, 16'h5A5A, 2'b10, 1, 0, 1, 3'd0, 1, 16'h0);      // R8 early strobe
    waitDone();
    issue(16'h4444, 16'h0,    2'b11, 0, 1, 1, 3'd5, 0, 16'h7700);   // waits on read
    waitDone();
    issue(16'h5555, 16'h0,    2'b11, 0, 0, 0, 3'd7, 1, 16'h8800);   // R4 waits ignored
    waitDone();

    // R9: request and config changes during an access
    issue(16'h6060, 16'h0, 2'b11, 0, 1, 1, 3'd3, 0, 16'h9900);
    reqValid = 1'b1; reqAddr = 16'hBEEF; reqWrite = 1'b1;
    cfgAddr3 = 0; cfgData3 = 0; cfgWaits = 3'd0; cfgStrbEarly = 1;
    repeat (3) @(negedge clk);
    reqValid = 1'b0;
    waitDone();
    repeat (6) @(negedge clk);
    chk(accesses == 6, "R9 no extra access", accesses, 6);

    issue(16'h7F7F, 16'hC3C3, 2'b01, 1, 1, 1, 3'd7, 1, 16'h0);      // longest write
    waitDone();
    repeat (5) @(negedge clk);
    chk(expQ.size() == 0 && accesses == issued, "R5 all accesses completed", accesses, issued);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule